// File: doc/BRIEF.md
# Keyed 32-bit Word Permutation Core

This block scrambles a 32-bit word under a 64-bit key with a lightweight Feistel-style network of 32 rounds on two 16-bit halves. A 2-bit lane number rotates which expanded key word each round uses inside every group of four rounds. The same data and key under the four lane values therefore give four unrelated results. A caller can combine those results into a wider keyed digest.

A one-cycle `start` pulse captures the word, the key and the lane. The core first expands the key into 32 round-key words, spending one clock on each new word. It then runs one round per clock. `done` pulses for one cycle when `result` holds the final word. `result` keeps that value until the next accepted `start`. While the core is working, `start` is ignored and the inputs may change freely.

Top module: `keyperm32`

## Requirements
- R1: After reset, `result` reads 0 and `done` reads 0.
- R2: The key is cut into four 16-bit seed words. Seed word 0 is `key_in[63:48]`, word 1 is `key_in[47:32]`, word 2 is `key_in[31:16]` and word 3 is `key_in[15:0]`.
- R3: Words 4 to 31 are built in order. For n = 0..27: t = rotr(w[n+3],3) XOR w[n+1], and w[n+4] = 0xFFFC XOR z_n XOR w[n] XOR t XOR rotr(t,1). Here z_n is bit 63−n of the constant 0xFA2561CDF44AC398.
- R4: Round r (r = 0..31) uses key word w[4·(r div 4) + ((r mod 4 + lane) mod 4)], where lane is the `lane_in` value captured at start.
- R5: Left starts as `data_in[15:0]` and right starts as `data_in[31:16]`. Each round sets new left = right XOR g(left) XOR round key and new right = old left, where g(x) = (rotl(x,1) AND rotl(x,8)) XOR rotl(x,2).
- R6: After the last round, `result[31:16]` is the final right half and `result[15:0]` is the final left half.
- R7: `done` is high for exactly one cycle, 60 clock edges after the edge that accepts `start`.
- R8: A `start` pulse, or a change of `data_in`, `key_in` or `lane_in`, while a computation is running has no effect on that computation's result or timing.
- R9: Once `done` has pulsed, `result` stays unchanged until another `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation; accepted only when idle |
| data_in | input | 32 | Word to permute, captured at start |
| key_in | input | 64 | Key, captured at start |
| lane_in | input | 2 | Round-key rotation selector, captured at start |
| result | output | 32 | Permuted word, valid from `done` onward |
| done | output | 1 | One-cycle pulse when `result` is valid |

## Verification
The embedded assertions watch the sequencing on every cycle. They check that `done` never lasts two cycles and occurs only when the core is idle. They check that a `start` during expansion or rounds never restarts the count, and that the seed words and the half registers stay frozen when nothing is meant to write them. They also check that each round moves the old left half into the right half. Only the bench scenarios can show that the arithmetic is right. These compare results against an independent model of the expansion, the lane rotation, the round function and the output half order, using directed keys and data, all four lanes and random vectors. The bench scenarios also show the exact 60-edge latency, the hold of `result` after `done`, and the immunity to input changes during a run.

// File: rtl/keyperm_pkg.sv
package keyperm_pkg;

  localparam int HW = 16;

  typedef logic [HW-1:0] hw_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EXP  = 2'd1,
    PH_RND  = 2'd2
  } phase_e;

  // rotate a halfword left by n positions
  function automatic hw_t rotl16(input hw_t x, input int unsigned n);
    logic [2*HW-1:0] d;
    d = {x, x} << n;
    return d[2*HW-1:HW];
  endfunction

  // rotate a halfword right by n positions
  function automatic hw_t rotr16(input hw_t x, input int unsigned n);
    logic [2*HW-1:0] d;
    d = {x, x} >> n;
    return d[HW-1:0];
  endfunction

  // nonlinear mixing applied to the left half each round
  function automatic hw_t mix16(input hw_t x);
    return (rotl16(x, 1) & rotl16(x, 8)) ^ rotl16(x, 2);
  endfunction

endpackage

// File: rtl/keyperm_ctrl.sv
module keyperm_ctrl
  import keyperm_pkg::*;
#(
  parameter int EXP_STEPS = 28,
  parameter int ROUNDS    = 32,
  localparam int MAXS     = (ROUNDS > EXP_STEPS) ? ROUNDS : EXP_STEPS,
  localparam int CNT_W    = $clog2(MAXS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             load,
  output logic             exp_en,
  output logic             rnd_en,
  output logic [CNT_W-1:0] step,
  output logic             done
);

  localparam logic [CNT_W-1:0] LAST_EXP = CNT_W'(EXP_STEPS - 1);
  localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] st_q, st_d;
  logic             done_q, done_d;

  assign load   = (ph_q == PH_IDLE) && start;
  assign exp_en = (ph_q == PH_EXP);
  assign rnd_en = (ph_q == PH_RND);
  assign step   = st_q;
  assign done   = done_q;

  always_comb begin
    ph_d   = ph_q;
    st_d   = st_q;
    done_d = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d = PH_EXP;
          st_d = '0;
        end
      end
      PH_EXP: begin
        if (st_q == LAST_EXP) begin
          ph_d = PH_RND;
          st_d = '0;
        end else begin
          st_d = st_q + 1'b1;
        end
      end
      PH_RND: begin
        if (st_q == LAST_RND) begin
          ph_d   = PH_IDLE;
          st_d   = '0;
          done_d = 1'b1;
        end else begin
          st_d = st_q + 1'b1;
        end
      end
      default: begin
        ph_d = PH_IDLE;
        st_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      st_q   <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (ph_q == PH_IDLE));

  assert_exp_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_EXP && start) |=> (st_q != '0 || ph_q == PH_RND));

  assert_rnd_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RND && start && st_q != LAST_RND) |=> (ph_q == PH_RND));

  assert_legal_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q != 2'd3);

endmodule

// File: rtl/keyperm_sched.sv
module keyperm_sched
  import keyperm_pkg::*;
#(
  parameter int          NWORDS  = 32,
  parameter logic [63:0] Z_SEQ   = 64'hFA25_61CD_F44A_C398,
  parameter hw_t         C_CONST = 16'hFFFC,
  localparam int         IDX_W   = $clog2(NWORDS),
  localparam int         KEY_W   = 4 * HW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [KEY_W-1:0] key,
  input  logic [1:0]       lane,
  input  logic             exp_en,
  input  logic [IDX_W-1:0] exp_idx,
  input  logic [IDX_W-1:0] rd_round,
  output hw_t              rkey
);

  hw_t        kw_q [NWORDS];
  hw_t        kw_d [NWORDS];
  logic [1:0] lane_q;
  logic       wr_en;

  logic [IDX_W-1:0] i1, i3, iw, addr;
  logic [1:0]       slot;
  logic [5:0]       zpos;
  logic             zb;
  hw_t              tmp, nw;

  assign wr_en = load | exp_en;

  // expansion of the next schedule word from three earlier ones
  always_comb begin
    i1   = exp_idx + IDX_W'(1);
    i3   = exp_idx + IDX_W'(3);
    iw   = exp_idx + IDX_W'(4);
    zpos = 6'd63 - 6'(exp_idx);
    zb   = Z_SEQ[zpos];
    tmp  = rotr16(kw_q[i3], 3) ^ kw_q[i1];
    nw   = C_CONST ^ {{(HW-1){1'b0}}, zb} ^ kw_q[exp_idx] ^ tmp ^ rotr16(tmp, 1);
  end

  always_comb begin
    kw_d = kw_q;
    if (load) begin
      for (int j = 0; j < 4; j++) begin
        kw_d[j] = key[KEY_W-1-HW*j -: HW];
      end
    end else if (exp_en) begin
      kw_d[iw] = nw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) begin
        kw_q[i] <= '0;
      end
      lane_q <= '0;
    end else begin
      if (wr_en) kw_q <= kw_d;
      if (load)  lane_q <= lane;
    end
  end

  // lane rotation stays inside the current group of four
  assign slot = rd_round[1:0] + lane_q;
  assign addr = {rd_round[IDX_W-1:2], slot};
  assign rkey = kw_q[addr];

  assert_seed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(kw_q[0]) && $stable(kw_q[1]) &&
               $stable(kw_q[2]) && $stable(kw_q[3])));

  assert_lane_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(lane_q));

  assert_load_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !exp_en);

endmodule

// File: rtl/keyperm_round.sv
module keyperm_round
  import keyperm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [2*HW-1:0] data,
  input  logic          rnd_en,
  input  hw_t           rkey,
  output logic [2*HW-1:0] res
);

  hw_t  lft_q, lft_d;
  hw_t  rgt_q, rgt_d;
  logic wr_en;

  assign wr_en = load | rnd_en;

  always_comb begin
    lft_d = lft_q;
    rgt_d = rgt_q;
    if (load) begin
      lft_d = data[HW-1:0];
      rgt_d = data[2*HW-1:HW];
    end else if (rnd_en) begin
      lft_d = rgt_q ^ mix16(lft_q) ^ rkey;
      rgt_d = lft_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lft_q <= '0;
      rgt_q <= '0;
    end else if (wr_en) begin
      lft_q <= lft_d;
      rgt_q <= rgt_d;
    end
  end

  assign res = {rgt_q, lft_q};

  assert_halves_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(load || rnd_en) |=> $stable(res));

  assert_round_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_en && !load) |=> (res[2*HW-1:HW] == $past(res[HW-1:0])));

endmodule

// File: rtl/keyperm32.sv
module keyperm32
  import keyperm_pkg::*;
#(
  parameter int ROUNDS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2*HW-1:0] data_in,
  input  logic [4*HW-1:0] key_in,
  input  logic [1:0]    lane_in,
  output logic [2*HW-1:0] result,
  output logic          done
);

  localparam int EXP_STEPS = ROUNDS - 4;
  localparam int IDX_W     = $clog2(ROUNDS);

  logic             load, exp_en, rnd_en;
  logic [IDX_W-1:0] step;
  hw_t              rkey;

  keyperm_ctrl #(
    .EXP_STEPS (EXP_STEPS),
    .ROUNDS    (ROUNDS)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .load   (load),
    .exp_en (exp_en),
    .rnd_en (rnd_en),
    .step   (step),
    .done   (done)
  );

  keyperm_sched #(
    .NWORDS (ROUNDS)
  ) u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .key      (key_in),
    .lane     (lane_in),
    .exp_en   (exp_en),
    .exp_idx  (step),
    .rd_round (step),
    .rkey     (rkey)
  );

  keyperm_round u_round (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .data   (data_in),
    .rnd_en (rnd_en),
    .rkey   (rkey),
    .res    (result)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !$past(load));

endmodule

// File: tb/keyperm32_test.sv
module keyperm32_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] data_in;
  logic [63:0] key_in;
  logic [1:0]  lane_in;
  logic [31:0] result;
  logic        done;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  keyperm32 uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .data_in (data_in),
    .key_in  (key_in),
    .lane_in (lane_in),
    .result  (result),
    .done    (done)
  );

  function automatic logic [15:0] rr(input logic [15:0] v, input int n);
    return (v >> n) | (v << (16 - n));
  endfunction

  function automatic logic [15:0] rl(input logic [15:0] v, input int n);
    return (v << n) | (v >> (16 - n));
  endfunction

  function automatic logic [31:0] model(input logic [31:0] x, input logic [63:0] key,
                                        input int lane);
    logic [15:0] k [32];
    logic [15:0] t, l, r, f, old;
    logic [63:0] zc;
    zc = 64'hFA25_61CD_F44A_C398;
    k[0] = key[63:48];
    k[1] = key[47:32];
    k[2] = key[31:16];
    k[3] = key[15:0];
    for (int n = 0; n < 28; n++) begin
      t = rr(k[n+3], 3) ^ k[n+1];
      k[n+4] = 16'hFFFC ^ {15'd0, zc[63-n]} ^ k[n] ^ t ^ rr(t, 1);
    end
    l = x[15:0];
    r = x[31:16];
    for (int rd = 0; rd < 32; rd++) begin
      f   = (rl(l, 1) & rl(l, 8)) ^ rl(l, 2);
      old = l;
      l   = r ^ f ^ k[4*(rd/4) + ((rd%4 + lane) % 4)];
      r   = old;
    end
    return {r, l};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] d, input logic [63:0] k, input logic [1:0] ln,
                     input bit inject, input string tag);
    logic [31:0] exp;
    int cyc;
    bit seen;
    exp = model(d, k, int'(ln));
    @(negedge clk);
    start = 1'b1; data_in = d; key_in = k; lane_in = ln;
    @(negedge clk);
    start = 1'b0; data_in = ~d; key_in = {k[31:0], k[63:32]}; lane_in = ln + 2'd1;
    cyc = 0;
    seen = 1'b0;
    for (int c = 0; c < 150; c++) begin
      @(negedge clk);
      cyc++;
      if (done) begin
        seen = 1'b1;
        break;
      end
      if (inject && cyc == 10) begin
        start = 1'b1; data_in = 32'h1357_9BDF; key_in = ~k; lane_in = ln + 2'd3;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    if (!seen) begin
      check({tag, " R7 timeout"}, 64'(cyc), 64'd60);
    end else begin
      check(tag, 64'(result), 64'(exp));
      check("R7 latency", 64'(cyc), 64'd60);
      @(negedge clk);
      check("R7 single pulse", 64'(done), 64'd0);
      repeat (3) @(negedge clk);
      check("R9 hold", 64'(result), 64'(exp));
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] k;
    void'($urandom(32'h00C0_FFEE));
    rst_n = 1'b0; start = 1'b0; data_in = '0; key_in = '0; lane_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 result", 64'(result), 64'd0);
    check("R1 done", 64'(done), 64'd0);

    // zero key and data: only the constant and z bits shape the output (R3)
    run(32'h0, 64'h0, 2'd0, 1'b0, "R3 zero");
    // seed word order matters (R2)
    run(32'h0, 64'h0001_0000_0000_0000, 2'd0, 1'b0, "R2 word0");
    run(32'h0, 64'h0000_0000_0000_0001, 2'd0, 1'b0, "R2 word3");
    // half mapping on input and output (R5, R6)
    run(32'hFFFF_0000, 64'h0, 2'd0, 1'b0, "R5 upper half");
    run(32'h0000_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1'b0, "R6 lower half");
    // every lane on one vector (R4)
    for (int ln = 0; ln < 4; ln++) begin
      run(32'hDEAD_BEEF, 64'h0123_4567_89AB_CDEF, 2'(ln), 1'b0, "R4 lane");
    end
    // start pulse and input changes during a run (R8)
    run(32'hCAFE_F00D, 64'h0F1E_2D3C_4B5A_6978, 2'd2, 1'b1, "R8 busy start");
    run(32'h8000_0001, 64'h8000_0000_0000_0001, 2'd3, 1'b1, "R8 busy start");
    // random vectors across all lanes (R3, R4, R5, R6)
    for (int i = 0; i < 40; i++) begin
      d = $urandom;
      k = {$urandom, $urandom};
      run(d, k, 2'(i % 4), (i % 7) == 3, "R3 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule